// File: doc/BRIEF.md
# DMA channel enable and interrupt control

This block is the control section of a single DMA channel. It keeps four control bits behind a small register port: a transfer enable, a master enable, an end-of-transfer interrupt enable and a break interrupt enable. From these bits it decides what happens to each activation request. When both enables are set, the request launches a transfer. When the transfer enable is clear, the request is dropped. If the dropped request came from an internal interrupt source, it is passed on to the processor as an ordinary interrupt.

The transfer enable is protected against stray writes. A write of 1 arms the channel only if the most recent access to the register was a read that returned the enable as 0. The enable falls when software writes 0 or when the external transfer counter pulses `count_done`. When the enable falls with the end interrupt enabled, the block raises a held end interrupt. When the master enable falls with the break interrupt enabled, the block raises a held break interrupt. The break interrupt is withdrawn when software clears its enable or sets the master enable again.

The block has no data stream, so every pin is a plain level or pulse and there is no back-pressure. All register updates take effect at the clock edge after the access. The start and forward outputs are combinational from the current request and the registered bits.

Top module: `dmac_chan_ctl`

## Requirements
- R1: After reset, all four control bits read as 0, the arming flag is clear, and `xfer_start`, `fwd_irq`, `end_irq` and `brk_irq` are all 0.
- R2: While the transfer enable is 0, `act_req` never produces `xfer_start`. In the same cycle, `fwd_irq` equals `act_req & act_is_irq`.
- R3: `xfer_start` is 1 in exactly those cycles where `act_req` is 1 and both the transfer enable and the master enable are 1. With the transfer enable at 1 and the master enable at 0, a request produces neither `xfer_start` nor `fwd_irq`.
- R4: A write with data bit 0 set turns the transfer enable on only if the previous register access was a read that returned it as 0. Any write clears this arming state. A write of 1 without arming leaves the enable at its current value.
- R5: The transfer enable becomes 0 after a write with data bit 0 clear, or after a cycle with `count_done` high. `count_done` wins over an armed write of 1 in the same cycle.
- R6: When the transfer enable goes from 1 to 0 and the end interrupt enable (data bit 2) is 1 after that edge, `end_irq` rises at that edge. It stays high, even across re-arming, until the end interrupt enable is cleared. No end interrupt is raised if that enable is 0.
- R7: When the master enable (data bit 1) goes from 1 to 0 and the break interrupt enable (data bit 3) is 1 after that edge, `brk_irq` rises at that edge and stays high.
- R8: A pending `brk_irq` drops at the edge where software either clears the break interrupt enable or sets the master enable back to 1.
- R9: `reg_rdata` shows the control bits at all times: bit 0 is the transfer enable, bit 1 the master enable, bit 2 the end interrupt enable, bit 3 the break interrupt enable. All higher bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Control bits readback |
| act_req | input | 1 | Activation request, one cycle per request |
| act_is_irq | input | 1 | Request comes from an internal interrupt source |
| count_done | input | 1 | Pulse from the transfer counter when the count runs out |
| xfer_start | output | 1 | One-cycle start for each accepted request |
| fwd_irq | output | 1 | Request passed on as a normal interrupt |
| end_irq | output | 1 | Held end-of-transfer interrupt |
| brk_irq | output | 1 | Held transfer-break interrupt |

## Verification
The gating is driven with requests from interrupt and non-interrupt sources under three settings: both enables clear, transfer enable set with master enable clear, and both set. This separates ignoring a request, forwarding it, and accepting it. The arming path is tried in three cases: a write with no prior read, a read followed by a write, and a read that is broken by an unrelated write. This shows that only an immediate read-then-write arms the channel. The enable is cleared by a counter pulse, by a software write, and by a counter pulse that collides with an armed write, with each interrupt enable on and off. This separates the end and break events and both ways of cancelling a break.

// File: rtl/dmac_ctl_pkg.sv
package dmac_ctl_pkg;
  localparam int FIELD_W = 4;
  localparam int EN_BIT  = 0;
  localparam int MEN_BIT = 1;
  localparam int EIE_BIT = 2;
  localparam int BIE_BIT = 3;
  localparam int N_IRQ   = 2;

  typedef struct packed {
    logic bie;
    logic eie;
    logic men;
    logic en;
  } ctl_bits_t;
endpackage

// File: rtl/dmac_ctl_regs.sv
module dmac_ctl_regs
  import dmac_ctl_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic               rd,
  input  logic [FIELD_W-1:0] wdata,
  input  logic               count_done,
  output ctl_bits_t          bits_q,
  output ctl_bits_t          bits_d,
  output logic               armed_q
);
  logic armed_d;

  always_comb begin
    bits_d  = bits_q;
    armed_d = armed_q;
    if (wr) begin
      armed_d     = 1'b0;
      bits_d.men  = wdata[MEN_BIT];
      bits_d.eie  = wdata[EIE_BIT];
      bits_d.bie  = wdata[BIE_BIT];
      if (!wdata[EN_BIT])
        bits_d.en = 1'b0;
      else if (armed_q)
        bits_d.en = 1'b1;
    end else if (rd && !bits_q.en) begin
      armed_d = 1'b1;
    end
    if (count_done)
      bits_d.en = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bits_q  <= '0;
      armed_q <= 1'b0;
    end else begin
      bits_q  <= bits_d;
      armed_q <= armed_d;
    end
  end
endmodule

// File: rtl/dmac_req_gate.sv
module dmac_req_gate (
  input  logic act_req,
  input  logic act_is_irq,
  input  logic en,
  input  logic men,
  output logic xfer_start,
  output logic fwd_irq
);
  always_comb begin
    xfer_start = act_req & en & men;
    fwd_irq    = act_req & act_is_irq & ~en;
  end
endmodule

// File: rtl/dmac_irq_latch.sv
module dmac_irq_latch #(
  parameter bit RESUME_CANCELS = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic src_q,
  input  logic src_d,
  input  logic ie_d,
  output logic irq
);
  logic irq_d;
  logic fell;
  logic keep;

  assign fell = src_q & ~src_d;
  assign keep = RESUME_CANCELS ? ~src_d : 1'b1;

  always_comb irq_d = ie_d & keep & (irq | fell);

  always_ff @(posedge clk) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= irq_d;
  end
endmodule

// File: rtl/dmac_chan_ctl.sv
module dmac_chan_ctl
  import dmac_ctl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              act_req,
  input  logic              act_is_irq,
  input  logic              count_done,
  output logic              xfer_start,
  output logic              fwd_irq,
  output logic              end_irq,
  output logic              brk_irq
);
  localparam int PAD_W = DATA_W - FIELD_W;

  ctl_bits_t bits_q, bits_d;
  logic      arm_flag;
  logic [N_IRQ-1:0] src_q, src_d, ie_d, irq_vec;
  logic      unused_hi;

  assign unused_hi = ^reg_wdata[DATA_W-1:FIELD_W];

  dmac_ctl_regs u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr         (reg_wr),
    .rd         (reg_rd),
    .wdata      (reg_wdata[FIELD_W-1:0]),
    .count_done (count_done),
    .bits_q     (bits_q),
    .bits_d     (bits_d),
    .armed_q    (arm_flag)
  );

  dmac_req_gate u_gate (
    .act_req    (act_req),
    .act_is_irq (act_is_irq),
    .en         (bits_q.en),
    .men        (bits_q.men),
    .xfer_start (xfer_start),
    .fwd_irq    (fwd_irq)
  );

  // index 0: end-of-transfer event, index 1: break event
  assign src_q = {bits_q.men, bits_q.en};
  assign src_d = {bits_d.men, bits_d.en};
  assign ie_d  = {bits_d.bie, bits_d.eie};

  for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
    dmac_irq_latch #(.RESUME_CANCELS(i == 1)) u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .src_q (src_q[i]),
      .src_d (src_d[i]),
      .ie_d  (ie_d[i]),
      .irq   (irq_vec[i])
    );
  end

  assign end_irq   = irq_vec[0];
  assign brk_irq   = irq_vec[1];
  assign reg_rdata = {{PAD_W{1'b0}}, bits_q};
endmodule

// File: rtl/dmac_chan_ctl_chk.sv
module dmac_chan_ctl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              act_req,
  input logic              act_is_irq,
  input logic              count_done,
  input logic              xfer_start,
  input logic              fwd_irq,
  input logic              end_irq,
  input logic              brk_irq,
  input logic              arm
);
  AST_FWD_ONLY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    fwd_irq |-> (!reg_rdata[0] && act_req && act_is_irq)); // R2
  AST_START_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |-> (act_req && reg_rdata[0] && reg_rdata[1])); // R3
  AST_ARM_BEFORE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_rdata[0]) |-> $past(arm && reg_wr && reg_wdata[0])); // R4
  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    count_done |=> !reg_rdata[0]); // R5
  AST_END_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(reg_rdata[0]) && reg_rdata[2]) |-> end_irq); // R6
  AST_END_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    end_irq |-> reg_rdata[2]); // R6
  AST_BRK_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(reg_rdata[1]) && reg_rdata[3]) |-> brk_irq); // R7
  AST_BRK_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
    brk_irq |-> (reg_rdata[3] && !reg_rdata[1])); // R8
  AST_RDATA_PAD: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rdata[DATA_W-1:4] == '0); // R9
endmodule

bind dmac_chan_ctl dmac_chan_ctl_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .reg_wdata  (reg_wdata),
  .reg_rdata  (reg_rdata),
  .act_req    (act_req),
  .act_is_irq (act_is_irq),
  .count_done (count_done),
  .xfer_start (xfer_start),
  .fwd_irq    (fwd_irq),
  .end_irq    (end_irq),
  .brk_irq    (brk_irq),
  .arm        (arm_flag)
);

// File: tb/dmac_chan_ctl_test.sv
`timescale 1ns/1ps
module dmac_chan_ctl_test;
  localparam int DATA_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [DATA_W-1:0] reg_wdata = '0;
  logic [DATA_W-1:0] reg_rdata;
  logic act_req = 1'b0, act_is_irq = 1'b0, count_done = 1'b0;
  logic xfer_start, fwd_irq, end_irq, brk_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  typedef struct {
    string      req;
    logic [11:0] exp;
  } item_t;
  item_t sb_q[$];

  always #2 clk = ~clk;

  dmac_chan_ctl #(.DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .act_req(act_req),
    .act_is_irq(act_is_irq), .count_done(count_done), .xfer_start(xfer_start),
    .fwd_irq(fwd_irq), .end_irq(end_irq), .brk_irq(brk_irq)
  );

  // observation: {rdata, start, fwd, end, brk}; bits = {bie,eie,men,en}
  function automatic logic [11:0] ob(logic [3:0] bits, logic st, logic fw,
                                     logic ei, logic bi);
    return {4'b0000, bits, st, fw, ei, bi};
  endfunction

  task automatic put(logic wr, logic rd, logic [3:0] wd, logic rq,
                     logic irq, logic done);
    @(negedge clk);
    reg_wr     = wr;
    reg_rd     = rd;
    reg_wdata  = {4'b0000, wd};
    act_req    = rq;
    act_is_irq = irq;
    count_done = done;
  endtask

  task automatic expect_now(string req, logic [11:0] exp);
    item_t it;
    it.req = req;
    it.exp = exp;
    sb_q.push_back(it);
  endtask

  // monitor: samples 1 ns after the falling edge, away from the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [11:0] act;
        it  = sb_q.pop_front();
        act = {reg_rdata, xfer_start, fwd_irq, end_irq, brk_irq};
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.req, act, it.exp);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    put(0,0,4'b0000,0,0,0); expect_now("R1 reset state", ob(4'b0000,0,0,0,0));
    put(0,0,4'b0000,1,1,0); expect_now("R2 forward irq source", ob(4'b0000,0,1,0,0));
    put(0,0,4'b0000,1,0,0); expect_now("R2 ignore plain source", ob(4'b0000,0,0,0,0));
    put(1,0,4'b0111,0,0,0); expect_now("R4 write cycle", ob(4'b0000,0,0,0,0));
    put(0,1,4'b0000,0,0,0); expect_now("R4 unarmed write R9", ob(4'b0110,0,0,0,0));
    put(1,0,4'b0111,0,0,0); expect_now("R4 armed write cycle", ob(4'b0110,0,0,0,0));
    put(0,0,4'b0000,1,1,0); expect_now("R3 start irq source", ob(4'b0111,1,0,0,0));
    put(0,0,4'b0000,1,0,0); expect_now("R3 start plain source", ob(4'b0111,1,0,0,0));
    put(0,0,4'b0000,0,0,1); expect_now("R5 done cycle", ob(4'b0111,0,0,0,0));
    put(0,0,4'b0000,0,0,0); expect_now("R5 R6 done clears end irq", ob(4'b0110,0,0,1,0));
    put(0,1,4'b0000,0,0,0); expect_now("R6 held", ob(4'b0110,0,0,1,0));
    put(1,0,4'b0111,0,0,0); expect_now("R6 held rearm", ob(4'b0110,0,0,1,0));
    put(0,0,4'b0000,0,0,0); expect_now("R6 held after rearm", ob(4'b0111,0,0,1,0));
    put(1,0,4'b0011,0,0,0); expect_now("R6 before clear", ob(4'b0111,0,0,1,0));
    put(1,0,4'b1011,0,0,0); expect_now("R6 cleared by ie R4 keep", ob(4'b0011,0,0,0,0));
    put(1,0,4'b1001,0,0,0); expect_now("R7 bie set", ob(4'b1011,0,0,0,0));
    put(0,0,4'b0000,1,1,0); expect_now("R7 break R3 men off", ob(4'b1001,0,0,0,1));
    put(1,0,4'b1011,0,0,0); expect_now("R7 held", ob(4'b1001,0,0,0,1));
    put(1,0,4'b1001,0,0,0); expect_now("R8 resume cancels", ob(4'b1011,0,0,0,0));
    put(1,0,4'b0001,0,0,0); expect_now("R7 second break", ob(4'b1001,0,0,0,1));
    put(1,0,4'b0000,0,0,0); expect_now("R8 ie clear cancels", ob(4'b0001,0,0,0,0));
    put(0,1,4'b0000,0,0,0); expect_now("R5 R6 sw clear no end", ob(4'b0000,0,0,0,0));
    put(1,0,4'b0010,0,0,0); expect_now("R4 read cycle", ob(4'b0000,0,0,0,0));
    put(1,0,4'b0011,0,0,0); expect_now("R4 intervening write", ob(4'b0010,0,0,0,0));
    put(0,1,4'b0000,0,0,0); expect_now("R4 stale arm", ob(4'b0010,0,0,0,0));
    put(1,0,4'b0111,0,0,1); expect_now("R5 collide cycle", ob(4'b0010,0,0,0,0));
    put(0,0,4'b0000,0,0,0); expect_now("R5 done wins", ob(4'b0110,0,0,0,0));
    @(negedge clk);
    #2;
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule